// File: doc/BRIEF.md
# Block-Device Read Controller with DMA and Completion Interrupt

The block lets a processor fetch one sector from a block storage device into main memory without copying a single word itself. Software first writes a logical block number and a destination byte address into two registers. It then writes the read opcode into the command register. The controller converts the block number into a surface, track and sector position and issues a one-cycle request carrying that position to the storage side. It then accepts the sector as a stream of 32-bit words and writes each word to main memory through a valid/ready write port. When the last word has been accepted by memory, it raises an interrupt. The interrupt stays up until software acknowledges it.

The sequencer has three states. IDLE waits for a valid start. ISSUE lasts one cycle and drives the storage request. MOVE carries words from the stream into memory. The transitions are: IDLE to ISSUE on an accepted read command, ISSUE to MOVE unconditionally, and MOVE to IDLE when memory accepts the final word of the sector. The disk geometry, the sector size and the word width are parameters. The defaults are 4 surfaces, 64 tracks per surface, 32 sectors per track, 512-byte sectors and 32-bit words, which gives 128 words per sector and 8192 addressable blocks.

Top module: `blkdma_ctrl`

## Requirements
- R1: Register index 1 holds the block number and index 2 holds the destination address; both read back what was last written. Writing index 0 with 0x01 in bits [7:0] while idle, with a block number below 8192, starts a read. Status (index 3) bit 0 reads 1 from the cycle after that write until the final memory write is accepted.
- R2: Let q be the block number divided by 32. The position is sector = block mod 32, surface = q mod 4, track = q / 4. This position is driven on the sector outputs with `sec_req` high for exactly the one cycle after the start. Index 4 reads it back as sector in bits [7:0], track in bits [15:8] and surface in bits [23:16].
- R3: Stream words are taken in order under valid/ready. Word k of a sector (k = 0 to 127) is written to destination + 4k with that word's data.
- R4: Exactly 128 memory writes occur per started read, and none while idle. While `mem_wready` is low, an offered write keeps `mem_wvalid`, address and data unchanged.
- R5: `irq` rises, and status bit 0 clears, on the clock edge at which memory accepts the final word.
- R6: `irq` and status bit 1 stay high until index 3 is written with bit 1 set; writing index 3 with bit 1 clear has no effect on them.
- R7: A read command written while a transfer is in progress sets status bit 2 (error). The running transfer continues to its original addresses and data and is not restarted.
- R8: A read command with a block number of 8192 or more sets status bit 2 and starts nothing.
- R9: A write to index 0 whose bits [7:0] differ from 0x01 changes neither busy, error nor interrupt, and produces no request.
- R10: Writes to indexes 1 and 2 during a transfer read back at once but do not alter the transfer in progress.
- R11: Writing index 3 with bit 2 set clears the error bit.
- R12: After reset, all registers read 0, and `irq`, `sec_req`, `sd_ready` and `mem_wvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| sec_req | output | 1 | One-cycle storage request |
| sec_surface | output | 2 | Requested surface |
| sec_track | output | 6 | Requested track |
| sec_sector | output | 5 | Requested sector |
| sd_valid | input | 1 | Stream word valid |
| sd_data | input | 32 | Stream word |
| sd_ready | output | 1 | Stream word accepted when high with `sd_valid` |
| mem_wvalid | output | 1 | Memory write offered |
| mem_wready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Completion interrupt, level |

## Verification
A status read reports busy one cycle after the command write. `sec_req` follows in the cycle after the start edge. A stream word accepted at one edge is offered to memory from that same edge, and `irq` and the busy clear take effect at the edge where memory accepts word 127. The bench drives inputs on falling edges and samples one nanosecond later, so every handshake it records is the one the next rising edge commits. Its behavioural model consumes those samples at that rising edge and compares `irq` and the request strobe on every cycle. The model also compares each accepted write against destination + 4k, and the stimulus includes runs where both handshakes stall at random.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_MOVE  = 2'd2
    } dma_state_e;

    localparam logic [2:0] IDX_CMD  = 3'd0;
    localparam logic [2:0] IDX_LBA  = 3'd1;
    localparam logic [2:0] IDX_DEST = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_GEOM = 3'd4;

    localparam logic [7:0] OP_READ = 8'h01;

    localparam int STAT_BUSY = 0;
    localparam int STAT_IRQ  = 1;
    localparam int STAT_ERR  = 2;

endpackage

// File: rtl/blkdma_geom.sv
module blkdma_geom #(
    parameter int DW     = 32,
    parameter int NSURF  = 4,
    parameter int NTRACK = 64,
    parameter int NSECT  = 32,
    parameter int SURFW  = 2,
    parameter int TRKW   = 6,
    parameter int SECW   = 5
) (
    input  logic [DW-1:0]    lba,
    output logic [SURFW-1:0] surf,
    output logic [TRKW-1:0]  trk,
    output logic [SECW-1:0]  sect,
    output logic             in_range
);
    localparam logic [DW-1:0] TOTAL_C = DW'(NSURF * NTRACK * NSECT);
    localparam logic [DW-1:0] NSECT_C = DW'(NSECT);
    localparam logic [DW-1:0] NSURF_C = DW'(NSURF);

    logic [DW-1:0] quo;
    logic [DW-1:0] sect_w;
    logic [DW-1:0] surf_w;
    logic [DW-1:0] trk_w;

    always_comb begin
        quo      = lba / NSECT_C;
        sect_w   = lba % NSECT_C;
        surf_w   = quo % NSURF_C;
        trk_w    = quo / NSURF_C;
        sect     = sect_w[SECW-1:0];
        surf     = surf_w[SURFW-1:0];
        trk      = trk_w[TRKW-1:0];
        in_range = lba < TOTAL_C;
    end
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SURFW = 2,
    parameter int TRKW  = 6,
    parameter int SECW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_idx,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             in_range,
    input  logic             busy,
    input  logic             done,
    input  logic [SURFW-1:0] pos_surf,
    input  logic [TRKW-1:0]  pos_trk,
    input  logic [SECW-1:0]  pos_sect,
    output logic [DW-1:0]    lba_q,
    output logic [DW-1:0]    dest_q,
    output logic             start,
    output logic             irq_q
);
    logic err_q;
    logic cmd_hit;
    logic err_set;
    logic stat_wr;

    always_comb begin
        cmd_hit = reg_we && (reg_idx == IDX_CMD) && (reg_wdata[7:0] == OP_READ);
        start   = cmd_hit && !busy && in_range;
        err_set = cmd_hit && (busy || !in_range);
        stat_wr = reg_we && (reg_idx == IDX_STAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lba_q  <= '0;
            dest_q <= '0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reg_we && reg_idx == IDX_LBA)  lba_q  <= reg_wdata;
            if (reg_we && reg_idx == IDX_DEST) dest_q <= reg_wdata;
            if (done)                                  irq_q <= 1'b1;
            else if (stat_wr && reg_wdata[STAT_IRQ])   irq_q <= 1'b0;
            if (err_set)                               err_q <= 1'b1;
            else if (stat_wr && reg_wdata[STAT_ERR])   err_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IDX_LBA:  reg_rdata = lba_q;
            IDX_DEST: reg_rdata = dest_q;
            IDX_STAT: begin
                reg_rdata[STAT_BUSY] = busy;
                reg_rdata[STAT_IRQ]  = irq_q;
                reg_rdata[STAT_ERR]  = err_q;
            end
            IDX_GEOM: begin
                reg_rdata[7:0]   = 8'(pos_sect);
                reg_rdata[15:8]  = 8'(pos_trk);
                reg_rdata[23:16] = 8'(pos_surf);
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
    import blkdma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WORDS = 128,
    parameter int SURFW = 2,
    parameter int TRKW  = 6,
    parameter int SECW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    dest,
    input  logic [SURFW-1:0] t_surf,
    input  logic [TRKW-1:0]  t_trk,
    input  logic [SECW-1:0]  t_sect,
    output logic             sec_req,
    output logic [SURFW-1:0] sec_surface,
    output logic [TRKW-1:0]  sec_track,
    output logic [SECW-1:0]  sec_sector,
    input  logic             sd_valid,
    input  logic [DW-1:0]    sd_data,
    output logic             sd_ready,
    output logic             mem_wvalid,
    input  logic             mem_wready,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             busy,
    output logic             done
);
    localparam int CNTW = $clog2(WORDS + 1);
    localparam logic [CNTW-1:0] WORDS_C = CNTW'(WORDS);
    localparam logic [CNTW-1:0] LAST_C  = CNTW'(WORDS - 1);
    localparam logic [DW-1:0]   STEP_C  = DW'(DW / 8);

    dma_state_e      state_q, state_d;
    logic [CNTW-1:0] in_cnt, out_cnt;
    logic [DW-1:0]   waddr;
    logic            in_fire, out_fire, last_out;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_MOVE;
            ST_MOVE:  if (last_out) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sec_req  = (state_q == ST_ISSUE);
        busy     = (state_q != ST_IDLE);
        sd_ready = (state_q == ST_MOVE) && (in_cnt != WORDS_C) && (!mem_wvalid || mem_wready);
        in_fire  = sd_valid && sd_ready;
        out_fire = mem_wvalid && mem_wready;
        last_out = (state_q == ST_MOVE) && out_fire && (out_cnt == LAST_C);
        done     = last_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_surface <= '0;
            sec_track   <= '0;
            sec_sector  <= '0;
            in_cnt      <= '0;
            out_cnt     <= '0;
            waddr       <= '0;
            mem_wvalid  <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
        end else if (start && state_q == ST_IDLE) begin
            sec_surface <= t_surf;
            sec_track   <= t_trk;
            sec_sector  <= t_sect;
            in_cnt      <= '0;
            out_cnt     <= '0;
            waddr       <= dest;
        end else begin
            if (in_fire) begin
                mem_wvalid <= 1'b1;
                mem_addr   <= waddr;
                mem_wdata  <= sd_data;
                waddr      <= waddr + STEP_C;
                in_cnt     <= in_cnt + 1'b1;
            end else if (out_fire) begin
                mem_wvalid <= 1'b0;
            end
            if (out_fire) out_cnt <= out_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl #(
    parameter int DW           = 32,
    parameter int NSURF        = 4,
    parameter int NTRACK       = 64,
    parameter int NSECT        = 32,
    parameter int SECTOR_BYTES = 512,
    localparam int SURFW = (NSURF  > 1) ? $clog2(NSURF)  : 1,
    localparam int TRKW  = (NTRACK > 1) ? $clog2(NTRACK) : 1,
    localparam int SECW  = (NSECT  > 1) ? $clog2(NSECT)  : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_idx,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             sec_req,
    output logic [SURFW-1:0] sec_surface,
    output logic [TRKW-1:0]  sec_track,
    output logic [SECW-1:0]  sec_sector,
    input  logic             sd_valid,
    input  logic [DW-1:0]    sd_data,
    output logic             sd_ready,
    output logic             mem_wvalid,
    input  logic             mem_wready,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             irq
);
    localparam int WORDS = SECTOR_BYTES / (DW / 8);

    logic [DW-1:0]    lba_q, dest_q;
    logic [SURFW-1:0] t_surf;
    logic [TRKW-1:0]  t_trk;
    logic [SECW-1:0]  t_sect;
    logic             in_range, start, busy, done;

    blkdma_geom #(
        .DW(DW), .NSURF(NSURF), .NTRACK(NTRACK), .NSECT(NSECT),
        .SURFW(SURFW), .TRKW(TRKW), .SECW(SECW)
    ) u_geom (
        .lba(lba_q), .surf(t_surf), .trk(t_trk), .sect(t_sect), .in_range(in_range)
    );

    blkdma_regs #(
        .DW(DW), .SURFW(SURFW), .TRKW(TRKW), .SECW(SECW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_range(in_range), .busy(busy), .done(done),
        .pos_surf(sec_surface), .pos_trk(sec_track), .pos_sect(sec_sector),
        .lba_q(lba_q), .dest_q(dest_q), .start(start), .irq_q(irq)
    );

    blkdma_fsm #(
        .DW(DW), .WORDS(WORDS), .SURFW(SURFW), .TRKW(TRKW), .SECW(SECW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .dest(dest_q),
        .t_surf(t_surf), .t_trk(t_trk), .t_sect(t_sect),
        .sec_req(sec_req), .sec_surface(sec_surface), .sec_track(sec_track), .sec_sector(sec_sector),
        .sd_valid(sd_valid), .sd_data(sd_data), .sd_ready(sd_ready),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_req,
    input logic          busy,
    input logic          sd_ready,
    input logic          mem_wvalid,
    input logic          mem_wready,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          irq,
    input logic          reg_we,
    input logic [2:0]    reg_idx,
    input logic [DW-1:0] reg_wdata
);
    // R2
    sec_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |=> !sec_req);

    // R1
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |-> busy);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_addr) && $stable(mem_wdata)));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_wvalid && !sd_ready));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_wvalid && mem_wready));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_we && reg_idx == 3'd3 && reg_wdata[1])) |=> irq);
endmodule

bind blkdma_ctrl blkdma_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sec_req(sec_req), .busy(busy), .sd_ready(sd_ready),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata)
);

// File: tb/blkdma_ctrl_bench.sv
module blkdma_ctrl_bench;
    localparam int NSURF  = 4;
    localparam int NTRACK = 64;
    localparam int NSECT  = 32;
    localparam int WORDS  = 128;
    localparam int TOTAL  = NSURF * NTRACK * NSECT;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_idx;
    logic [31:0] reg_wdata, reg_rdata;
    logic        sec_req;
    logic [1:0]  sec_surface;
    logic [5:0]  sec_track;
    logic [4:0]  sec_sector;
    logic        sd_valid = 1'b0;
    logic [31:0] sd_data = '0;
    logic        sd_ready;
    logic        mem_wvalid;
    logic        mem_wready = 1'b1;
    logic [31:0] mem_addr, mem_wdata;
    logic        irq;

    always #4 clk = ~clk;

    blkdma_ctrl u_blkdma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_req(sec_req),
        .sec_surface(sec_surface), .sec_track(sec_track), .sec_sector(sec_sector),
        .sd_valid(sd_valid), .sd_data(sd_data), .sd_ready(sd_ready),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] lba, input int k);
        return {lba[15:0] ^ 16'h5A3C, 16'(k)};
    endfunction

    function automatic logic [31:0] geom_of(input logic [31:0] lba);
        int b, q;
        b = int'(lba);
        q = b / NSECT;
        return {8'h00, 8'(q % NSURF), 8'(q / NSURF), 8'(b % NSECT)};
    endfunction

    // samples taken 1 ns after each falling edge
    logic        c_rst = 1'b0, c_we = 1'b0, c_irq = 1'b0, c_sec_req = 1'b0;
    logic        c_sd_hs = 1'b0, c_mem_hs = 1'b0;
    logic [2:0]  c_idx = '0;
    logic [31:0] c_wdata = '0, c_maddr = '0, c_mdata = '0, c_geom = '0;

    // behavioural model state
    logic        irq_m = 1'b0, err_m = 1'b0, busy_m = 1'b0, issue_m = 1'b0;
    logic [31:0] lba_m = '0, dest_m = '0, cur_lba = '0, cur_dest = '0;
    int          k_m = 0;

    // stream source and memory stall generator
    logic        stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          src_idx = 0;
    logic [31:0] src_lba = '0;
    logic        src_on = 1'b0;

    always @(negedge clk) begin
        if (c_sec_req) begin
            src_idx = 0;
            src_lba = cur_lba;
            src_on  = 1'b1;
        end else if (c_sd_hs) begin
            src_idx++;
        end
        lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sd_valid   = src_on && (src_idx < WORDS) && (!stall || lfsr[0] || lfsr[4]);
        sd_data    = word_of(src_lba, src_idx);
        mem_wready = !stall || lfsr[2] || lfsr[7];
        #1;
        c_rst     = rst_n;
        c_we      = reg_we;
        c_idx     = reg_idx;
        c_wdata   = reg_wdata;
        c_irq     = irq;
        c_sec_req = sec_req;
        c_geom    = {8'h00, 8'(sec_surface), 8'(sec_track), 8'(sec_sector)};
        c_sd_hs   = sd_valid && sd_ready;
        c_mem_hs  = mem_wvalid && mem_wready;
        c_maddr   = mem_addr;
        c_mdata   = mem_wdata;
    end

    always @(posedge clk) begin
        if (!c_rst) begin
            irq_m = 1'b0; err_m = 1'b0; busy_m = 1'b0; issue_m = 1'b0;
            lba_m = '0; dest_m = '0; k_m = 0;
        end else begin
            logic done_now;
            done_now = 1'b0;
            check("R5 R6 irq level", {31'b0, c_irq}, {31'b0, irq_m});
            check("R2 request timing", {31'b0, c_sec_req}, {31'b0, issue_m});
            if (c_sec_req) check("R2 geometry on request", c_geom, geom_of(cur_lba));
            issue_m = 1'b0;
            if (c_mem_hs) begin
                if (!busy_m) begin
                    check("R4 write while idle", 32'd1, 32'd0);
                end else begin
                    check("R3 write address", c_maddr, cur_dest + 32'(4 * k_m));
                    check("R3 write data", c_mdata, word_of(cur_lba, k_m));
                    k_m++;
                    if (k_m == WORDS) begin
                        busy_m = 1'b0; irq_m = 1'b1; done_now = 1'b1;
                    end
                end
            end
            if (c_we) begin
                case (c_idx)
                    3'd0: if (c_wdata[7:0] == 8'h01) begin
                        if (busy_m || lba_m >= 32'(TOTAL)) err_m = 1'b1;
                        else begin
                            busy_m = 1'b1; issue_m = 1'b1; k_m = 0;
                            cur_lba = lba_m; cur_dest = dest_m;
                        end
                    end
                    3'd1: lba_m = c_wdata;
                    3'd2: dest_m = c_wdata;
                    3'd3: begin
                        if (c_wdata[1] && !done_now) irq_m = 1'b0;
                        if (c_wdata[2]) err_m = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_idx = idx;
        #2;
        val = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n;
        n = 0;
        while (irq !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'b0, irq}, 32'd1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_idx = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(3'd1, v); check("R12 lba after reset", v, 0);
        rd(3'd2, v); check("R12 dest after reset", v, 0);
        rd(3'd3, v); check("R12 status after reset", v, 0);
        rd(3'd4, v); check("R12 position after reset", v, 0);
        check("R12 outputs after reset", {28'b0, irq, sec_req, sd_ready, mem_wvalid}, 0);

        // R1 R2 R3 R5 R6: plain transfer, no stalls
        wr(3'd1, 32'd37);
        wr(3'd2, 32'h0000_1000);
        wr(3'd0, 32'h0000_0001);
        rd(3'd3, v); check("R1 busy after start", v, 32'd1);
        wait_irq("R5 completion interrupt");
        rd(3'd3, v); check("R5 status at completion", v, 32'd2);
        rd(3'd4, v); check("R2 position readback 37", v, geom_of(32'd37));
        repeat (10) @(negedge clk);
        wr(3'd3, 32'd0);
        rd(3'd3, v); check("R6 write without clear bit keeps irq", v, 32'd2);
        wr(3'd3, 32'd2);
        rd(3'd3, v); check("R6 status after clear", v, 32'd0);
        check("R6 irq port after clear", {31'b0, irq}, 0);

        // R4 R7 R10: stalled transfer with interference
        stall = 1'b1;
        wr(3'd1, 32'd1000);
        wr(3'd2, 32'h0000_2000);
        wr(3'd0, 32'h0000_0001);
        repeat (20) @(negedge clk);
        wr(3'd0, 32'h0000_0001);
        rd(3'd3, v); check("R7 busy and error on repeat command", v, 32'd5);
        wr(3'd1, 32'd77);
        wr(3'd2, 32'h0000_9000);
        rd(3'd1, v); check("R10 lba readback during transfer", v, 32'd77);
        rd(3'd2, v); check("R10 dest readback during transfer", v, 32'h0000_9000);
        rd(3'd4, v); check("R10 position unchanged", v, geom_of(32'd1000));
        wait_irq("R4 stalled transfer completes");
        rd(3'd3, v); check("R7 status after stalled transfer", v, 32'd6);
        wr(3'd3, 32'd6);
        rd(3'd3, v); check("R11 error and irq cleared", v, 32'd0);

        // R9: other opcodes ignored
        wr(3'd0, 32'h0000_0002);
        wr(3'd0, 32'h0000_00FF);
        repeat (3) @(negedge clk);
        rd(3'd3, v); check("R9 status after foreign opcodes", v, 32'd0);
        check("R9 no stream acceptance", {31'b0, sd_ready}, 0);

        // R8 R11: block number out of range
        wr(3'd1, 32'(TOTAL));
        wr(3'd0, 32'h0000_0001);
        repeat (3) @(negedge clk);
        rd(3'd3, v); check("R8 out of range sets error only", v, 32'd4);
        wr(3'd3, 32'd4);
        rd(3'd3, v); check("R11 error cleared", v, 32'd0);

        // R2 R3: last block, stalled
        wr(3'd1, 32'(TOTAL - 1));
        wr(3'd2, 32'h0003_0000);
        wr(3'd0, 32'h0000_0001);
        wait_irq("R5 last block completes");
        rd(3'd4, v); check("R2 position readback last block", v, geom_of(32'(TOTAL - 1)));
        wr(3'd3, 32'd2);
        rd(3'd3, v); check("R6 final clear", v, 32'd0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule